// File: doc/BRIEF.md
# Overlapping-Window Register File

This block holds the general registers of a 32-bit load-store core. Software always addresses 32 logical registers, but the physical store is larger. Logical numbers 0 to 7 are global and reach the same eight physical cells in every window. Numbers 8 to 31 reach a 24-register slice of the physical array, and the position of that slice is set by a current-window pointer.

A save command, issued on procedure entry, moves the pointer down by one window of 16 physical registers. The registers the caller saw as 8..15 then appear to the callee as 24..31, so arguments pass with no copying. A restore command, issued on procedure exit, moves the pointer back up and the callee's 24..31 return as the caller's 8..15. A save at the lowest window or a restore at the highest window does not move the pointer. Instead it raises an overflow or underflow flag for one cycle, so that outside logic can spill or refill memory.

The block has two combinational read ports and one write port that commits on the clock edge. A read of the register being written in the same cycle returns the incoming data.

Top module: `winreg_file`

## Requirements
- R1: After reset the window pointer equals NWIN-1 (the top window), and both the overflow and underflow flags are 0.
- R2: Logical registers 0..7 map to the same physical registers in every window, so a value written to one of them is read back unchanged after any number of saves and restores.
- R3: A save with the pointer above 0 lowers the pointer by 1 on the next clock edge. The value the caller wrote to logical register 8+k (k = 0..7) is then read by the callee as logical register 24+k.
- R4: Logical registers 16..23 are private to a window. A write to them in the callee does not change the caller's registers 16..23, which read back their old values after the restore.
- R5: A save when the pointer is 0 leaves the pointer unchanged and sets the overflow flag for exactly the cycle after the command.
- R6: A restore when the pointer is NWIN-1 leaves the pointer unchanged and sets the underflow flag for exactly the cycle after the command.
- R7: When the write enable is high and the write index equals a read index, that read port returns the write data in the same cycle.
- R8: The two read ports work independently, and each returns the register that its own index selects in the current window.
- R9: A cycle with save and restore both high moves no pointer and sets no flag.
- R10: A write that occurs in the same cycle as a save or a restore uses the window that was current before the pointer moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 5 | Read port A logical index |
| rd_a_data | output | W | Read port A data |
| rd_b_idx | input | 5 | Read port B logical index |
| rd_b_data | output | W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write logical index |
| wr_data | input | W | Write data |
| save_cmd | input | 1 | Move the window down (procedure entry) |
| restore_cmd | input | 1 | Move the window up (procedure exit) |
| cwp_o | output | CW | Current window pointer |
| ovf | output | 1 | Save was refused at window 0 (one-cycle pulse) |
| unf | output | 1 | Restore was refused at the top window (one-cycle pulse) |

## Verification
The bench first drives the pointer down to window 0 and then one save further, and it drives the pointer up to the top and one restore further. A design with a bad edge test would wrap the pointer to the other end of the array, and the bench would then read the wrong registers. It writes the caller's registers 8..15 and reads them back as the callee's 24..31. An off-by-one in the window step would return locals or stale data at that point. It also checks a write issued in the same cycle as a save, a same-cycle read of the register being written, and a cycle with save and restore both high. A design that got these wrong would store the value in the new window, return stale data, or move the pointer anyway. Finally a long run of random operations is compared against a behavioural model on every clock.

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int NWIN = 4,
  parameter int W    = 32,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    rd_a_idx,
  output logic [W-1:0]  rd_a_data,
  input  logic [4:0]    rd_b_idx,
  output logic [W-1:0]  rd_b_data,
  input  logic          wr_en,
  input  logic [4:0]    wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          save_cmd,
  input  logic          restore_cmd,
  output logic [CW-1:0] cwp_o,
  output logic          ovf,
  output logic          unf
);
  localparam int NPHYS = 16 * NWIN + 16;
  localparam int PW    = $clog2(NPHYS);
  localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

  logic [W-1:0]  regs [NPHYS];
  logic [CW-1:0] cwp;
  logic [PW-1:0] pa, pb, pw;
  logic          do_save, do_rest;

  function automatic logic [PW-1:0] phys(input logic [4:0] r, input logic [CW-1:0] w);
    if (r < 5'd8) return PW'(r);
    return PW'({w, 4'b0000}) + PW'(r);
  endfunction

  assign pa = phys(rd_a_idx, cwp);
  assign pb = phys(rd_b_idx, cwp);
  assign pw = phys(wr_idx, cwp);

  assign rd_a_data = (wr_en && wr_idx == rd_a_idx) ? wr_data : regs[pa];
  assign rd_b_data = (wr_en && wr_idx == rd_b_idx) ? wr_data : regs[pb];

  assign do_save = save_cmd & ~restore_cmd;
  assign do_rest = restore_cmd & ~save_cmd;
  assign cwp_o   = cwp;

  always_ff @(posedge clk)
    if (wr_en) regs[pw] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp <= TOP;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= do_save && cwp == '0;
      unf <= do_rest && cwp == TOP;
      if (do_save && cwp != '0)      cwp <= cwp - 1'b1;
      else if (do_rest && cwp != TOP) cwp <= cwp + 1'b1;
    end
  end

  p_cwp_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cwp_o <= TOP);
  p_save_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (save_cmd && !restore_cmd && cwp_o != '0) |=> (cwp_o == $past(cwp_o) - 1'b1 && !ovf));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (save_cmd && !restore_cmd && cwp_o == '0) |=> ($stable(cwp_o) && ovf));
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_cmd && !save_cmd && cwp_o == TOP) |=> ($stable(cwp_o) && unf));
  p_both_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (save_cmd && restore_cmd) |=> ($stable(cwp_o) && !ovf && !unf));
  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_a_idx) |-> rd_a_data == wr_data);
endmodule

// File: tb/sim_winreg_file.sv
module sim_winreg_file;
  localparam int PERIOD = 10;
  localparam int NWIN = 4;
  localparam int CW = $clog2(NWIN);

  logic clk = 0, rst_n = 0;
  logic [4:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0;
  logic wr_en = 0, save_cmd = 0, restore_cmd = 0;
  logic [CW-1:0] cwp_o;
  logic ovf, unf;

  winreg_file #(.NWIN(NWIN), .W(32)) u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int m_cwp;
  bit m_ovf, m_unf;
  logic [31:0] mem_m [int];

  function automatic int pidx(int w, int r);
    return (r < 8) ? r : 16 * w + r;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit we, int wi, logic [31:0] wd, int ra, int rb, bit sv, bit rs, string tag);
    int pa, pb;
    wr_en = we; wr_idx = 5'(wi); wr_data = wd; rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
    save_cmd = sv; restore_cmd = rs;
    #1;
    chk(cwp_o == CW'(m_cwp), {tag, " cwp"}, 32'(cwp_o), 32'(m_cwp));
    chk(ovf == m_ovf, {tag, " R5 ovf"}, 32'(ovf), 32'(m_ovf));
    chk(unf == m_unf, {tag, " R6 unf"}, 32'(unf), 32'(m_unf));
    pa = pidx(m_cwp, ra); pb = pidx(m_cwp, rb);
    if (we && wi == ra) chk(rd_a_data == wd, {tag, " R7 bypass A"}, rd_a_data, wd);
    else if (mem_m.exists(pa)) chk(rd_a_data == mem_m[pa], {tag, " R8 port A"}, rd_a_data, mem_m[pa]);
    if (we && wi == rb) chk(rd_b_data == wd, {tag, " R7 bypass B"}, rd_b_data, wd);
    else if (mem_m.exists(pb)) chk(rd_b_data == mem_m[pb], {tag, " R8 port B"}, rd_b_data, mem_m[pb]);
    @(posedge clk);
    if (we) mem_m[pidx(m_cwp, wi)] = wd;
    m_ovf = sv && !rs && m_cwp == 0;
    m_unf = rs && !sv && m_cwp == NWIN - 1;
    if (sv && !rs && m_cwp > 0) m_cwp--;
    else if (rs && !sv && m_cwp < NWIN - 1) m_cwp++;
    @(negedge clk);
  endtask

  task automatic peek(int ra, logic [31:0] exp, string tag);
    rd_a_idx = 5'(ra); wr_en = 0; save_cmd = 0; restore_cmd = 0;
    #1;
    chk(rd_a_data == exp, tag, rd_a_data, exp);
    @(posedge clk); m_ovf = 0; m_unf = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_cwp = NWIN - 1; m_ovf = 0; m_unf = 0;
    repeat (2) @(negedge clk);
    #1;
    chk(cwp_o == CW'(NWIN - 1), "R1 reset cwp", 32'(cwp_o), NWIN - 1);
    chk(ovf == 0 && unf == 0, "R1 reset flags", {30'b0, ovf, unf}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    #1;
    chk(cwp_o == CW'(NWIN - 1), "R1 cwp after release", 32'(cwp_o), NWIN - 1);

    cyc(1, 3, 32'hA0A0_0003, 0, 0, 0, 0, "R2 write global");
    cyc(1, 17, 32'h1111_0017, 0, 0, 0, 0, "R4 caller local");
    cyc(1, 9, 32'h0909_0909, 0, 0, 0, 0, "R3 caller out");
    cyc(0, 0, 0, 0, 0, 1, 0, "R3 save");
    chk(cwp_o == CW'(NWIN - 2), "R3 cwp stepped", 32'(cwp_o), NWIN - 2);
    peek(25, 32'h0909_0909, "R3 out seen as in");
    peek(3, 32'hA0A0_0003, "R2 global in callee");
    cyc(1, 17, 32'h2222_0017, 0, 0, 0, 0, "R4 callee local");
    cyc(1, 26, 32'hCAFE_0026, 17, 0, 0, 1, "R10 write with restore");
    peek(17, 32'h1111_0017, "R4 caller local kept");
    peek(10, 32'hCAFE_0026, "R10 result in caller out");
    cyc(1, 5, 32'h5555_5555, 5, 3, 0, 0, "R7 same-cycle read");
    cyc(0, 0, 0, 5, 3, 0, 0, "R8 both ports");
    cyc(0, 0, 0, 0, 0, 0, 1, "R6 restore at top");
    chk(unf == 1 && cwp_o == CW'(NWIN - 1), "R6 underflow flag", {31'b0, unf}, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, "R6 flag clears");
    cyc(1, 12, 32'h0C0C_0012, 0, 0, 1, 0, "R10 write with save");
    peek(28, 32'h0C0C_0012, "R10 write landed in old window");
    for (int i = 0; i < NWIN; i++) cyc(0, 0, 0, 0, 0, 1, 0, "R5 descend");
    chk(ovf == 1 && cwp_o == 0, "R5 overflow flag", {31'b0, ovf}, 1);
    cyc(0, 0, 0, 0, 0, 1, 1, "R9 both commands");
    chk(ovf == 0 && unf == 0 && cwp_o == 0, "R9 no action", {30'b0, ovf, unf}, 0);
    peek(3, 32'hA0A0_0003, "R2 global at window 0");

    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom_range(0, 9);
      cyc($urandom_range(0, 1), $urandom_range(0, 31), $urandom,
          $urandom_range(0, 31), $urandom_range(0, 31),
          op == 0 || op == 9, op == 1 || op == 9, "R8 random");
    end
    finish_run();
  end
endmodule